// File: doc/BRIEF.md
# Byte-wide many-time-programmable memory model

This block is a synthesizable clocked model of a byte-organised non-volatile memory that is rewritten only by an external programming station. Active-low chip enable, output enable and write enable, together with two digital flags, select its mode. The flags stand for a raised programming voltage, one on the output-enable pin and one on address bit 9. The modes are read, output disable, standby, byte program, chip erase and identifier read. The data bus is split into an input byte, an output byte and a drive enable, so that a pad ring can join them into one bidirectional bus.

Erase can only move bits to 1, and programming can only move them to 0. Each operation runs for a parameterised number of clock cycles. During that time a busy output is high and further write-enable pulses are ignored. If a voltage flag is withdrawn before the count ends, the operation is abandoned and an error flag is raised. The decoded address width, `ADDR_W` (16 to 19), selects the device identifier byte. The physically held storage is `2**STORE_AW` bytes, indexed by the low address bits, so higher address bits alias.

Top module: `mtp_byte_mem`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `oe_hv`=0; in every other combination the output is floated (`dq_oe`=0).
- R2: With `ce_n`=1 (standby) no operation starts, whatever the other controls do, and stored contents are unchanged.
- R3: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=0, a high-to-low step of `we_n` seen on a clock edge starts a byte program of `dq_in` at `addr`. The result is readable once busy has dropped.
- R4: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=1, a falling `we_n` starts a chip erase. On completion every byte reads 8'hFF, whatever `addr` and `dq_in` held.
- R5: A program stores the bitwise AND of the old byte and `dq_in`, so a 0 bit is never returned to 1 by programming.
- R6: With `ce_n`=0, `oe_n`=0, `oe_hv`=0 and `a9_hv`=1, the output is an identifier. `addr[0]`=0 gives 8'hBF. `addr[0]`=1 gives the device code, which is 8'hC4, 8'hC5, 8'hC6 or 8'hC2 for `ADDR_W` of 16, 17, 18 or 19.
- R7: `busy` rises on the clock edge that detects the starting `we_n` fall. It stays high for exactly `PROG_CYC` cycles for a program, or exactly `ERASE_CYC` cycles for an erase.
- R8: Falling edges of `we_n` while `busy` is high start nothing: the running operation keeps its length, address and data.
- R9: If `oe_hv` drops during any operation, or `a9_hv` drops during an erase, `busy` falls on the next edge and `err` rises. `err` holds until the next accepted start, which clears it. The affected contents are then undefined.
- R10: After reset `busy`=0, `err`=0, and with idle controls `dq_oe`=0.
- R11: Reads index storage with `addr[STORE_AW-1:0]` only; addresses that differ only above that field read the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its falling step starts operations |
| oe_hv | input | 1 | Programming voltage present on output enable |
| a9_hv | input | 1 | Programming voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data presented for programming |
| dq_out | output | 8 | Read or identifier data |
| dq_oe | output | 1 | Output drive enable for the data bus |
| busy | output | 1 | Program or erase countdown running |
| err | output | 1 | Last operation was abandoned |

## Verification
The bench sweeps the whole held array of a small configuration: an erase, two program passes and the read-back of each.

A wrong decoded mode shows as a drive enable in the wrong cycle, or as an identifier in place of array data, in the same cycle as the control change. A wrong counter or start detector shows as a busy window of the wrong length, within one operation. A wrong write path, such as a plain write instead of an AND, or a write to the wrong index, shows on the first read-back after busy falls. An abort path that fails to stop shows as busy still high on the cycle after the flag drops.

// File: rtl/mtp_pkg.sv
// Shared types for the byte-wide MTP memory model.
// Assumes ADDR_W in 16..19 when a device code is looked up.
package mtp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_DIS,
        M_READ,
        M_IDENT,
        M_PROG,
        M_ERASE
    } mtp_mode_e;

    localparam logic [7:0] MFR_CODE = 8'hBF;

    // Identifier byte chosen by decoded address width.
    function automatic logic [7:0] dev_code(input int aw);
        case (aw)
            16:      return 8'hC4;
            17:      return 8'hC5;
            18:      return 8'hC6;
            default: return 8'hC2;
        endcase
    endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
// Combinational mode decoder. Chip enable high wins over everything;
// the two voltage flags outrank the logic-level output enable.
// Assumes inputs are already synchronous to the block clock.
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      oe_hv,
    input  logic      a9_hv,
    output mtp_mode_e mode,
    output logic      drive
);

    // Priority decode of the control pins into one mode.
    always_comb begin
        if (ce_n)                mode = M_STANDBY;
        else if (oe_hv && a9_hv) mode = M_ERASE;
        else if (oe_hv)          mode = M_PROG;
        else if (oe_n)           mode = M_OUT_DIS;
        else if (a9_hv)          mode = M_IDENT;
        else                     mode = M_READ;
    end

    // Bus is driven only in the two reading modes.
    assign drive = (mode == M_READ) || (mode == M_IDENT);

endmodule

// File: rtl/mtp_op_seq.sv
// Program/erase sequencer: detects the write-enable fall, latches the
// operation, counts it down, and aborts when a voltage flag is lost.
// Assumes PROG_CYC and ERASE_CYC are at least 1.
module mtp_op_seq
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PROG_CYC  = 500,
    parameter int ERASE_CYC = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mtp_mode_e         mode,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              err,
    output logic              prog_commit,
    output logic              erase_commit,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             we_q;
    logic             op_erase;
    logic [CNT_W-1:0] cnt;
    logic             we_fall;
    logic             lost;
    logic             done;

    assign we_fall = we_q && !we_n;
    assign lost    = !oe_hv || (op_erase && !a9_hv);
    assign done    = busy && !lost && (cnt == '0);

    assign prog_commit  = done && !op_erase;
    assign erase_commit = done && op_erase;

    // Start, count down, finish or abort one operation at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            busy     <= 1'b0;
            err      <= 1'b0;
            op_erase <= 1'b0;
            cnt      <= '0;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            we_q <= we_n;
            if (busy) begin
                if (lost) begin
                    busy <= 1'b0;
                    err  <= 1'b1;
                end else if (cnt == '0) begin
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (we_fall && (mode == M_PROG || mode == M_ERASE)) begin
                busy     <= 1'b1;
                err      <= 1'b0;
                op_erase <= (mode == M_ERASE);
                cnt      <= (mode == M_ERASE) ? CNT_W'(ERASE_CYC - 1)
                                              : CNT_W'(PROG_CYC - 1);
                op_addr  <= addr;
                op_data  <= din;
            end
        end
    end

endmodule

// File: rtl/mtp_array.sv
// Byte storage of 2**STORE_AW locations. Erase sets all bytes to FFh,
// program ANDs new data into one byte. Contents are not reset: they
// model non-volatile cells. Upper address bits are not decoded.
module mtp_array #(
    parameter int ADDR_W   = 16,
    parameter int STORE_AW = 6
) (
    input  logic              clk,
    input  logic              prog_commit,
    input  logic              erase_commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [7:0]          cells [DEPTH];
    logic [STORE_AW-1:0] wr_idx;
    logic [STORE_AW-1:0] rd_idx;
    logic                unused_hi;

    assign wr_idx    = wr_addr[STORE_AW-1:0];
    assign rd_idx    = rd_addr[STORE_AW-1:0];
    assign unused_hi = ^{wr_addr[ADDR_W-1:STORE_AW], rd_addr[ADDR_W-1:STORE_AW]};

    // Apply a completed erase or program to the cells.
    always_ff @(posedge clk) begin
        if (erase_commit) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (prog_commit) begin
            cells[wr_idx] <= cells[wr_idx] & wr_data;
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/mtp_byte_mem.sv
// Top of the byte-wide MTP memory model: mode decode, operation
// sequencer, storage and read multiplexer. The data bus is split into
// input, output and drive enable; read data follows the inputs without
// a register. Assumes 16 <= ADDR_W <= 19 and STORE_AW <= ADDR_W.
module mtp_byte_mem
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int STORE_AW  = 6,
    parameter int PROG_CYC  = 500,
    parameter int ERASE_CYC = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              busy,
    output logic              err
);

    localparam logic [7:0] DEV_CODE = dev_code(ADDR_W);

    mtp_mode_e         mode;
    logic              drive;
    logic              prog_commit;
    logic              erase_commit;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic [7:0]        arr_q;

    mtp_mode_dec u_dec (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .oe_hv (oe_hv),
        .a9_hv (a9_hv),
        .mode  (mode),
        .drive (drive)
    );

    mtp_op_seq #(
        .ADDR_W    (ADDR_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .we_n         (we_n),
        .oe_hv        (oe_hv),
        .a9_hv        (a9_hv),
        .addr         (addr),
        .din          (dq_in),
        .busy         (busy),
        .err          (err),
        .prog_commit  (prog_commit),
        .erase_commit (erase_commit),
        .op_addr      (op_addr),
        .op_data      (op_data)
    );

    mtp_array #(
        .ADDR_W   (ADDR_W),
        .STORE_AW (STORE_AW)
    ) u_arr (
        .clk          (clk),
        .prog_commit  (prog_commit),
        .erase_commit (erase_commit),
        .wr_addr      (op_addr),
        .wr_data      (op_data),
        .rd_addr      (addr),
        .rd_data      (arr_q)
    );

    // Choose identifier or stored byte for the output.
    always_comb begin
        if (mode == M_IDENT) dq_out = addr[0] ? DEV_CODE : MFR_CODE;
        else                 dq_out = arr_q;
    end

    assign dq_oe = drive;

endmodule

// File: rtl/mtp_byte_mem_chk.sv
// Property checker for mtp_byte_mem, attached by bind below.
module mtp_byte_mem_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              oe_hv,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_out,
    input logic              dq_oe,
    input logic              busy,
    input logic              err
);

    p_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || oe_hv) |-> !dq_oe);

    p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ce_n) |=> !busy);

    p_start_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!ce_n && oe_hv && !we_n));

    p_mfr_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && a9_hv && !addr[0]) |-> (dq_out == 8'hBF));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !oe_hv) |=> (!busy && err));

    p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

endmodule

bind mtp_byte_mem mtp_byte_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .oe_hv  (oe_hv),
    .a9_hv  (a9_hv),
    .addr   (addr),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .busy   (busy),
    .err    (err)
);

// File: tb/sim_mtp_byte_mem.sv
module sim_mtp_byte_mem;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 17;
    localparam int SAW        = 6;
    localparam int DEPTH      = 1 << SAW;
    localparam int PCYC       = 4;
    localparam int ECYC       = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          oe_hv = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe, busy, err;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtp_byte_mem #(
        .ADDR_W(AW), .STORE_AW(SAW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy), .err(err)
    );

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    function automatic logic [7:0] pat_b(input int a);
        return 8'(((a * 53) & 255) ^ 8'hA5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 0; oe_n = 0; oe_hv = 0; a9_hv = 0; we_n = 1;
        addr = AW'(a);
        #1;
        d = dq_out;
    endtask

    // Start a program or erase and count the busy cycles.
    task automatic hv_op(input bit erase, input int a, input logic [7:0] d, output int nb);
        nb = 0;
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = erase; we_n = 1;
        addr = AW'(a); dq_in = d;
        @(negedge clk);
        we_n = 0;
        for (int g = 0; g < ECYC + 20; g++) begin
            @(negedge clk);
            we_n = 1;
            if (!busy) break;
            nb++;
        end
        oe_hv = 0; a9_hv = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] keep3, keep5;
        int nb;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check(busy == 0, "R10 busy", busy, 0);
        check(err == 0, "R10 err", err, 0);
        check(dq_oe == 0, "R10 float", dq_oe, 0);

        // R1: every combination of ce_n, oe_n, oe_hv
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            ce_n = c[0]; oe_n = c[1]; oe_hv = c[2]; a9_hv = 0; we_n = 1;
            #1;
            check(dq_oe == (c == 0), "R1 drive", dq_oe, c == 0);
        end

        // R4, R7: erase with junk address and data
        hv_op(1, 42, 8'h00, nb);
        check(nb == ECYC, "R7 erase busy length", nb, ECYC);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, d);
            check(d == 8'hFF, "R4 erased byte", d, 8'hFF);
        end

        // R3, R7: program every byte with pattern A
        for (int a = 0; a < DEPTH; a++) begin
            hv_op(0, a, pat_a(a), nb);
            check(nb == PCYC, "R7 program busy length", nb, PCYC);
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, d);
            check(d == pat_a(a), "R3 programmed byte", d, pat_a(a));
        end

        // R5: second pass ANDs into the first
        for (int a = 0; a < DEPTH; a++) hv_op(0, a, pat_b(a), nb);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, d);
            check(d == (pat_a(a) & pat_b(a)), "R5 and-merge", d, pat_a(a) & pat_b(a));
        end

        // R11: upper address bits alias
        for (int a = 0; a < DEPTH; a += 7) begin
            rd(a | (1 << 12) | (1 << SAW), d);
            check(d == (pat_a(a) & pat_b(a)), "R11 alias", d, pat_a(a) & pat_b(a));
        end

        // R6: identifier bytes, and float with oe_n high
        @(negedge clk);
        ce_n = 0; oe_n = 0; oe_hv = 0; a9_hv = 1; addr = AW'(2);
        #1;
        check(dq_oe && dq_out == 8'hBF, "R6 manufacturer", dq_out, 8'hBF);
        @(negedge clk);
        addr = AW'(3);
        #1;
        check(dq_oe && dq_out == 8'hC5, "R6 device", dq_out, 8'hC5);
        @(negedge clk);
        oe_n = 1;
        #1;
        check(dq_oe == 0, "R1 ident float", dq_oe, 0);
        a9_hv = 0;

        // R2: standby ignores a program pulse
        @(negedge clk);
        ce_n = 1; oe_n = 1; oe_hv = 1; a9_hv = 0; addr = AW'(9); dq_in = 8'h00;
        @(negedge clk);
        we_n = 0;
        @(negedge clk);
        we_n = 1;
        check(busy == 0, "R2 no start", busy, 0);
        @(negedge clk);
        oe_hv = 0;
        rd(9, d);
        check(d == (pat_a(9) & pat_b(9)), "R2 byte kept", d, pat_a(9) & pat_b(9));

        // R8: second pulse during busy is ignored
        keep3 = pat_a(3) & pat_b(3);
        keep5 = pat_a(5) & pat_b(5);
        nb = 0;
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = 0; addr = AW'(3); dq_in = 8'hF0; we_n = 1;
        @(negedge clk);
        we_n = 0;
        for (int g = 0; g < ECYC + 20; g++) begin
            @(negedge clk);
            we_n = (g != 1);
            if (g == 1) begin addr = AW'(5); dq_in = 8'h00; end
            if (!busy) break;
            nb++;
        end
        oe_hv = 0;
        check(nb == PCYC, "R8 length kept", nb, PCYC);
        rd(3, d);
        check(d == (keep3 & 8'hF0), "R8 first op applied", d, keep3 & 8'hF0);
        rd(5, d);
        check(d == keep5, "R8 second pulse ignored", d, keep5);

        // R9: abort erase by dropping a9_hv
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = 1; we_n = 1;
        @(negedge clk);
        we_n = 0;
        repeat (3) @(negedge clk);
        we_n = 1;
        check(busy == 1, "R9 running", busy, 1);
        a9_hv = 0;
        @(negedge clk);
        check(busy == 0, "R9 busy dropped", busy, 0);
        check(err == 1, "R9 err raised", err, 1);
        oe_hv = 0;
        repeat (2) @(negedge clk);
        check(err == 1, "R9 err held", err, 1);

        // R9: next accepted start clears err
        hv_op(0, 0, 8'hFF, nb);
        check(err == 0, "R9 err cleared", err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule